// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit turns a logical reference into a 24-bit physical address. A reference is a segment selector, a 16-bit byte offset and an access kind. Each segment is described by a descriptor with a physical base, a length in bytes and a one-bit segment type: a data segment or an access segment, the latter holding descriptors rather than plain data. Every translation is checked against three things. The selector must be in the permitted set given as a bit mask. The access kind must match the segment type. The offset must lie inside the segment.

Recently used descriptors are kept in a small fully associative cache, so a hit answers one cycle after the request is accepted. On a miss the unit raises a fetch on an external descriptor table port and holds it until the table answers. It then writes the returned descriptor into the cache, replacing entries in round-robin order, and answers in the following cycle. Only one request is in flight at a time. A flush input empties the cache.

Top module: `seg_xlate`

## Requirements
- R1: After reset `rspValid` and `tblReq` are 0, `reqReady` is 1 and the cache holds no entry, so the first reference to any permitted selector fetches from the table.
- R2: A reference that passes every check answers with `rspFault` 0, `rspCause` 00 and `rspAddr` equal to the descriptor base plus the zero-extended offset, modulo 2^24.
- R3: A reference that is accepted while its selector is cached answers in the very next cycle and raises no table fetch.
- R4: On a miss, `tblReq` rises in the cycle after acceptance with `tblSel` equal to the selector. It stays high, with `reqReady` low, until the cycle in which `tblAck` is sampled high. The answer appears in the cycle after that.
- R5: If bit `reqSel` of `permMask` is 0, the reference answers in the next cycle with cause 01 and raises no fetch. This check has the highest priority.
- R6: An offset greater than or equal to the segment length gives cause 11. Every faulting answer has `rspFault` 1 and `rspAddr` 0.
- R7: `reqKind` 00 (data read) and 01 (data write) need a data segment (`tblType` 0). `reqKind` 1x (descriptor access) needs an access segment (`tblType` 1). A mismatch gives cause 10, which has priority over the length check.
- R8: The cache holds 4 descriptors. Fills go to entries in round-robin order starting at entry 0, so the fifth distinct fill evicts the first descriptor filled.
- R9: A cycle with `invalidate` high empties the cache and restarts the fill order at entry 0. A fill in that same cycle is dropped. The next reference to any selector fetches again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| invalidate | input | 1 | Empties the descriptor cache |
| permMask | input | 16 | One bit per selector; 1 means access is permitted |
| reqValid | input | 1 | A translation request is presented |
| reqReady | output | 1 | Unit can accept a request this cycle |
| reqSel | input | 4 | Segment selector |
| reqOffset | input | 16 | Byte offset inside the segment |
| reqKind | input | 2 | 00 data read, 01 data write, 1x descriptor access |
| tblReq | output | 1 | Descriptor fetch request to the table |
| tblSel | output | 4 | Selector whose descriptor is wanted |
| tblAck | input | 1 | Table reply valid; descriptor fields are on the bus |
| tblBase | input | 24 | Returned segment base |
| tblLen | input | 17 | Returned segment length in bytes (up to 65536) |
| tblType | input | 1 | Returned segment type, 1 = access segment |
| rspValid | output | 1 | Translation result valid for one cycle |
| rspAddr | output | 24 | Physical address, 0 on a fault |
| rspFault | output | 1 | The translation faulted |
| rspCause | output | 2 | 00 none, 01 not permitted, 10 type mismatch, 11 out of bounds |

## Verification
The assertions assume that the table raises `tblAck` only while `tblReq` is high, for a single cycle, with descriptor fields that belong to `tblSel`. They also assume that `reqValid` is only counted while `reqReady` is high and that `invalidate` is not pulsed in the cycle a hit is looked up. The bench's table responder answers only pending fetches, after a programmable delay, and drops its acknowledge in the following cycle. The bench issues each request only after the previous answer has been seen, and pulses the flush while the unit is idle.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  localparam int PHYS_W = 24;
  localparam int OFF_W  = 16;
  localparam int LEN_W  = OFF_W + 1;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_PERM   = 2'b01,
    CAUSE_TYPE   = 2'b10,
    CAUSE_BOUNDS = 2'b11
  } cause_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic fillEntry;
    logic rspFromCache;
    logic rspFromTable;
    logic rspPermFault;
  } xlate_strobe_t;

  typedef struct packed {
    cause_e            cause;
    logic [PHYS_W-1:0] addr;
  } xlate_result_t;

  // type check ranks above the length check
  function automatic xlate_result_t judgeAccess(
    input logic [PHYS_W-1:0] segBase,
    input logic [LEN_W-1:0]  segLen,
    input logic              segIsAccess,
    input logic [OFF_W-1:0]  offset,
    input logic [1:0]        kind
  );
    xlate_result_t res;
    res.addr  = '0;
    res.cause = CAUSE_NONE;
    if (segIsAccess != kind[1]) begin
      res.cause = CAUSE_TYPE;
    end else if ({1'b0, offset} >= segLen) begin
      res.cause = CAUSE_BOUNDS;
    end else begin
      res.addr = segBase + PHYS_W'(offset);
    end
    return res;
  endfunction

endpackage

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          permOk,
  input  logic          cacheHit,
  input  logic          tblAck,
  output logic          reqReady,
  output logic          tblReq,
  output xlate_strobe_t strobe
);

  typedef enum logic {ST_IDLE, ST_FETCH} state_e;

  state_e state, nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (!permOk) begin
            strobe.rspPermFault = 1'b1;
          end else if (cacheHit) begin
            strobe.rspFromCache = 1'b1;
          end else begin
            strobe.latchReq = 1'b1;
            nextState       = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        if (tblAck) begin
          strobe.fillEntry    = 1'b1;
          strobe.rspFromTable = 1'b1;
          nextState           = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign reqReady = (state == ST_IDLE);
  assign tblReq   = (state == ST_FETCH);

  // R4: fetch request stays up until the table answers
  assert_fetch_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    (tblReq && !tblAck) |=> tblReq);

  // R4: no new request is taken while a fetch is open
  assert_busy_during_fetch_R4: assert property (@(posedge clk) disable iff (!rstN)
    tblReq |-> !reqReady);

  // R5: a refused selector never reaches the table
  assert_no_fetch_on_refusal_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !permOk) |=> !tblReq);

endmodule

// File: rtl/seg_xlate_dp.sv
module seg_xlate_dp
  import seg_xlate_pkg::*;
#(
  parameter int SEL_W   = 4,
  parameter int ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              invalidate,
  input  xlate_strobe_t     strobe,
  input  logic [SEL_W-1:0]  reqSel,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic [1:0]        reqKind,
  input  logic [PHYS_W-1:0] tblBase,
  input  logic [LEN_W-1:0]  tblLen,
  input  logic              tblType,
  output logic              cacheHit,
  output logic [SEL_W-1:0]  heldSel,
  output logic              rspValid,
  output logic [PHYS_W-1:0] rspAddr,
  output cause_e            rspCause
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] entValid;
  logic [ENTRIES-1:0] entType;
  logic [ENTRIES-1:0] hitVec;
  logic [SEL_W-1:0]   entTag  [ENTRIES];
  logic [PHYS_W-1:0]  entBase [ENTRIES];
  logic [LEN_W-1:0]   entLen  [ENTRIES];
  logic [IDX_W-1:0]   fillPtr;

  logic [OFF_W-1:0]   heldOff;
  logic [1:0]         heldKind;

  logic [PHYS_W-1:0]  hitBase;
  logic [LEN_W-1:0]   hitLen;
  logic               hitType;
  xlate_result_t      nextRes;

  // tag compare, one comparator per entry
  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_match
    assign hitVec[gi] = entValid[gi] && (entTag[gi] == reqSel);
  end

  assign cacheHit = |hitVec;

  always_comb begin
    hitBase = '0;
    hitLen  = '0;
    hitType = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hitVec[i]) begin
        hitBase = entBase[i];
        hitLen  = entLen[i];
        hitType = entType[i];
      end
    end
  end

  // valid bits and fill pointer; flush wins over a fill
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid <= '0;
      fillPtr  <= '0;
    end else if (invalidate) begin
      entValid <= '0;
      fillPtr  <= '0;
    end else if (strobe.fillEntry) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (fillPtr == IDX_W'(i)) entValid[i] <= 1'b1;
      end
      fillPtr <= (fillPtr == LAST_IDX) ? '0 : fillPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fillEntry && !invalidate) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (fillPtr == IDX_W'(i)) begin
          entTag[i]  <= heldSel;
          entBase[i] <= tblBase;
          entLen[i]  <= tblLen;
          entType[i] <= tblType;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldSel  <= '0;
      heldOff  <= '0;
      heldKind <= '0;
    end else if (strobe.latchReq) begin
      heldSel  <= reqSel;
      heldOff  <= reqOffset;
      heldKind <= reqKind;
    end
  end

  always_comb begin
    nextRes.cause = CAUSE_NONE;
    nextRes.addr  = '0;
    if (strobe.rspPermFault) begin
      nextRes.cause = CAUSE_PERM;
    end else if (strobe.rspFromCache) begin
      nextRes = judgeAccess(hitBase, hitLen, hitType, reqOffset, reqKind);
    end else if (strobe.rspFromTable) begin
      nextRes = judgeAccess(tblBase, tblLen, tblType, heldOff, heldKind);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspAddr  <= '0;
      rspCause <= CAUSE_NONE;
    end else begin
      rspValid <= strobe.rspPermFault | strobe.rspFromCache | strobe.rspFromTable;
      rspAddr  <= nextRes.addr;
      rspCause <= nextRes.cause;
    end
  end

  // R8: a selector never sits in two entries
  assert_single_match_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // R9: after a flush nothing matches
  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rstN)
    invalidate |=> !cacheHit);

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int SEL_W   = 4,
  parameter int ENTRIES = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  invalidate,
  input  logic [(1<<SEL_W)-1:0] permMask,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic [SEL_W-1:0]      reqSel,
  input  logic [15:0]           reqOffset,
  input  logic [1:0]            reqKind,
  output logic                  tblReq,
  output logic [SEL_W-1:0]      tblSel,
  input  logic                  tblAck,
  input  logic [23:0]           tblBase,
  input  logic [16:0]           tblLen,
  input  logic                  tblType,
  output logic                  rspValid,
  output logic [23:0]           rspAddr,
  output logic                  rspFault,
  output logic [1:0]            rspCause
);

  xlate_strobe_t strobe;
  logic          permOk;
  logic          cacheHit;
  cause_e        causeQ;

  assign permOk = permMask[reqSel];

  seg_xlate_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .permOk   (permOk),
    .cacheHit (cacheHit),
    .tblAck   (tblAck),
    .reqReady (reqReady),
    .tblReq   (tblReq),
    .strobe   (strobe)
  );

  seg_xlate_dp #(.SEL_W(SEL_W), .ENTRIES(ENTRIES)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .invalidate (invalidate),
    .strobe     (strobe),
    .reqSel     (reqSel),
    .reqOffset  (reqOffset),
    .reqKind    (reqKind),
    .tblBase    (tblBase),
    .tblLen     (tblLen),
    .tblType    (tblType),
    .cacheHit   (cacheHit),
    .heldSel    (tblSel),
    .rspValid   (rspValid),
    .rspAddr    (rspAddr),
    .rspCause   (causeQ)
  );

  assign rspCause = causeQ;
  assign rspFault = (causeQ != CAUSE_NONE);

  // R3: a hit answers next cycle without touching the table
  assert_hit_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && permOk && cacheHit) |=> (rspValid && !tblReq));

  // R4: answer follows the table acknowledge by one cycle
  assert_reply_after_ack_R4: assert property (@(posedge clk) disable iff (!rstN)
    (tblReq && tblAck) |=> rspValid);

  // R5: refusal reported in the next cycle
  assert_refusal_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !permOk) |=> (rspValid && rspCause == 2'b01));

  // R6: a faulting answer carries no address
  assert_fault_zero_addr_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault) |-> (rspAddr == '0));

endmodule

// File: tb/seg_xlate_tb_top.sv
`timescale 1ns/1ps
module seg_xlate_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        invalidate = 1'b0;
  logic [15:0] permMask = 16'hFDFF;   // selector 9 refused
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [3:0]  reqSel = '0;
  logic [15:0] reqOffset = '0;
  logic [1:0]  reqKind = '0;
  logic        tblReq;
  logic [3:0]  tblSel;
  logic        tblAck = 1'b0;
  logic [23:0] tblBase = '0;
  logic [16:0] tblLen = '0;
  logic        tblType = 1'b0;
  logic        rspValid;
  logic [23:0] rspAddr;
  logic        rspFault;
  logic [1:0]  rspCause;

  always #4 clk = ~clk;

  seg_xlate dut_i (
    .clk(clk), .rstN(rstN), .invalidate(invalidate), .permMask(permMask),
    .reqValid(reqValid), .reqReady(reqReady), .reqSel(reqSel),
    .reqOffset(reqOffset), .reqKind(reqKind), .tblReq(tblReq), .tblSel(tblSel),
    .tblAck(tblAck), .tblBase(tblBase), .tblLen(tblLen), .tblType(tblType),
    .rspValid(rspValid), .rspAddr(rspAddr), .rspFault(rspFault), .rspCause(rspCause)
  );

  int nChecks = 0;
  int nFail = 0;
  int fetchCount = 0;
  int ackDelay = 2;
  int waitCnt = 0;
  bit finished = 0;

  // descriptor model: base = sel*0x101000, len = 0x400*(sel+1), sel 6 is an access segment,
  // sel 15 sits at the top of memory with a full-size segment
  function automatic logic [23:0] modelBase(input logic [3:0] s);
    return (s == 4'd15) ? 24'hFFF000 : 24'(s) * 24'h101000;
  endfunction
  function automatic logic [16:0] modelLen(input logic [3:0] s);
    return (s == 4'd15) ? 17'h10000 : 17'h400 * (17'(s) + 17'd1);
  endfunction

  task automatic expectEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // table responder
  initial begin
    forever begin
      @(negedge clk);
      if (tblReq && !tblAck) begin
        waitCnt++;
        if (waitCnt >= ackDelay) begin
          tblAck  = 1'b1;
          tblBase = modelBase(tblSel);
          tblLen  = modelLen(tblSel);
          tblType = (tblSel == 4'd6);
          fetchCount++;
          waitCnt = 0;
        end
      end else begin
        tblAck = 1'b0;
      end
    end
  end

  task automatic doXlate(input logic [3:0] s, input logic [15:0] o, input logic [1:0] k,
                         output logic [1:0] cause, output logic [23:0] addr,
                         output logic flt, output bit fetched, output int lat);
    int f0;
    f0 = fetchCount;
    @(negedge clk);
    reqValid = 1'b1; reqSel = s; reqOffset = o; reqKind = k;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    while (!rspValid && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    cause = rspCause; addr = rspAddr; flt = rspFault;
    fetched = (fetchCount != f0);
  endtask

  typedef struct packed {
    logic [3:0]  sel;
    logic [15:0] off;
    logic [1:0]  kind;
    logic        expFetch;
    logic [1:0]  expCause;
    logic [23:0] expAddr;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    '{4'd1,  16'h0010, 2'd0, 1'b1, 2'd0, 24'h101010},
    '{4'd1,  16'h07FF, 2'd1, 1'b0, 2'd0, 24'h1017FF},
    '{4'd1,  16'h0800, 2'd0, 1'b0, 2'd3, 24'h000000},
    '{4'd9,  16'h0000, 2'd0, 1'b0, 2'd1, 24'h000000},
    '{4'd6,  16'h0004, 2'd0, 1'b1, 2'd2, 24'h000000},
    '{4'd6,  16'h0004, 2'd2, 1'b0, 2'd0, 24'h606004},
    '{4'd15, 16'h2000, 2'd0, 1'b1, 2'd0, 24'h001000},
    '{4'd2,  16'hFFFF, 2'd0, 1'b1, 2'd3, 24'h000000},
    '{4'd3,  16'h0000, 2'd2, 1'b1, 2'd2, 24'h000000},
    '{4'd1,  16'h0000, 2'd0, 1'b1, 2'd0, 24'h101000},
    '{4'd15, 16'hFFFF, 2'd1, 1'b0, 2'd0, 24'h00EFFF},
    '{4'd6,  16'h0000, 2'd2, 1'b1, 2'd0, 24'h606000},
    '{4'd9,  16'hFFFF, 2'd2, 1'b0, 2'd1, 24'h000000},
    '{4'd6,  16'hFFFF, 2'd0, 1'b0, 2'd2, 24'h000000},
    '{4'd15, 16'h0000, 2'd0, 1'b1, 2'd0, 24'hFFF000}
  };

  function automatic string causeTag(input logic [1:0] c);
    case (c)
      2'd1:    return "R5 refusal";
      2'd2:    return "R7 type";
      2'd3:    return "R6 bounds";
      default: return "R2 address";
    endcase
  endfunction

  initial begin
    logic [1:0]  cause;
    logic [23:0] addr;
    logic        flt;
    bit          fetched;
    int          lat;

    repeat (3) @(negedge clk);
    // R1 reset state
    expectEq("R1 rspValid at reset", rspValid, 0);
    expectEq("R1 reqReady at reset", reqReady, 1);
    expectEq("R1 tblReq at reset", tblReq, 0);
    rstN = 1'b1;
    @(negedge clk);
    expectEq("R1 reqReady after reset", reqReady, 1);

    for (int v = 0; v < NVEC; v++) begin
      doXlate(VECS[v].sel, VECS[v].off, VECS[v].kind, cause, addr, flt, fetched, lat);
      expectEq($sformatf("%s vec%0d cause", causeTag(VECS[v].expCause), v), cause, VECS[v].expCause);
      expectEq($sformatf("%s vec%0d addr", causeTag(VECS[v].expCause), v), addr, VECS[v].expAddr);
      expectEq($sformatf("R6 vec%0d fault flag", v), flt, (VECS[v].expCause != 2'd0));
      expectEq($sformatf("R8 vec%0d table fetch", v), fetched, VECS[v].expFetch);
      if (!VECS[v].expFetch) expectEq($sformatf("R3 vec%0d latency", v), lat, 1);
    end

    // R4: slow table, request held with the selector, intake closed
    ackDelay = 6;
    @(negedge clk);
    reqValid = 1'b1; reqSel = 4'd5; reqOffset = 16'h0020; reqKind = 2'd1;
    @(negedge clk);
    reqValid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      expectEq("R4 tblReq held", tblReq, 1);
      expectEq("R4 tblSel", tblSel, 5);
      expectEq("R4 reqReady low", reqReady, 0);
      expectEq("R4 no early answer", rspValid, 0);
      @(negedge clk);
    end
    while (!tblAck) @(negedge clk);
    expectEq("R4 no answer in ack cycle", rspValid, 0);
    @(negedge clk);
    expectEq("R4 answer after ack", rspValid, 1);
    expectEq("R4 address", rspAddr, 24'h505020);
    ackDelay = 2;

    // R9: cached selector, flush, then it must fetch again
    doXlate(4'd1, 16'h0000, 2'd0, cause, addr, flt, fetched, lat);
    expectEq("R9 hit before flush", fetched, 0);
    @(negedge clk);
    invalidate = 1'b1;
    @(negedge clk);
    invalidate = 1'b0;
    doXlate(4'd1, 16'h0004, 2'd0, cause, addr, flt, fetched, lat);
    expectEq("R9 miss after flush", fetched, 1);
    expectEq("R9 address after refill", addr, 24'h101004);
    doXlate(4'd6, 16'h0000, 2'd2, cause, addr, flt, fetched, lat);
    expectEq("R9 second selector misses", fetched, 1);
    doXlate(4'd1, 16'h0008, 2'd0, cause, addr, flt, fetched, lat);
    expectEq("R3 refilled entry hits", fetched, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL R4 watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule